// File: doc/BRIEF.md
# Load Queue with Store Ordering Check

This block is a circular queue of in-flight loads for an out-of-order core. Loads are allocated at the tail in program order, each carrying a sequence number, and the queue returns the slot index it used. When a load's effective address becomes known, the execution stage writes it into that slot. Committed loads retire from the head. On a pipeline flush, younger loads are removed from the tail. At allocation the block also hands back the store-queue position the load must remember: the current store tail, or an all-ones code when the store queue is empty.

When a store executes, it presents the load-queue tail position it captured when it was allocated, together with its own address. The block walks forward from that position to the current tail, looking for a load whose address has already been recorded and falls in the same 256-byte block as the store. The first such load in walk order is held as the ordering violator until the consumer takes it. While a violator is pending, further store checks are not evaluated.

The ring has one spare slot beyond the configured depth, so head equal to tail always means empty.

Top module: `load_order_queue`

## Requirements
- R1: The ring has DEPTH+1 slots and holds at most DEPTH loads. The queue is full when (tail+1) mod (DEPTH+1) equals head. While full, `alloc_ready` is 0 and a request on `alloc_valid` leaves the occupancy unchanged.
- R2: An accepted allocation stores `alloc_seq` in the slot shown on `alloc_idx` (the current tail). From the next cycle, the tail has advanced by one, wrapping from DEPTH to 0, and `occupancy` has grown by one.
- R3: `alloc_sq_tag` combinationally shows all ones (SQW+1 bits) when `alloc_sq_empty` is 1. Otherwise it shows `alloc_sq_tail` zero-extended by one bit.
- R4: With `commit_valid`, loads are removed from the head in order while the queue is not empty and the head's sequence number is less than or equal to `commit_seq`. Removal stops at the first younger load. The result shows on `occupancy` in the next cycle.
- R5: With `squash_valid`, loads are removed from the newest backwards while their sequence number is greater than `squash_seq`. The tail moves back once per removed load, wrapping from 0 to DEPTH.
- R6: `upd_valid` records `upd_addr` for the occupied slot `upd_idx` and marks its address valid. A request naming an unoccupied slot is ignored. A slot whose address is not yet valid never matches a store check.
- R7: A store check (`chk_valid`) visits the slots from `chk_start` forward, up to but not including the current tail. A slot matches when addr[AW-1:8] equals `chk_addr`[AW-1:8]. The first match in visiting order sets `vio_pending` and `vio_idx` in the next cycle. With no match, nothing changes.
- R8: While `vio_pending` is 1, store checks are skipped and `vio_idx` holds its value. `vio_take` clears `vio_pending` in the next cycle.
- R9: An allocation requested in the same cycle as `squash_valid` is refused. Asserting `commit_valid` and `squash_valid` together is illegal.
- R10: After reset, the queue is empty, head and tail are 0, `alloc_ready` is 1 and no violator is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load this cycle |
| alloc_seq | input | SEQW | Sequence number of the new load |
| alloc_sq_empty | input | 1 | Store queue currently empty |
| alloc_sq_tail | input | SQW | Current store-queue tail |
| alloc_ready | output | 1 | Queue can accept a load |
| alloc_idx | output | IDXW | Current tail: slot for the next load; stores capture it |
| alloc_sq_tag | output | SQW+1 | Store-queue position to record with the load |
| occupancy | output | IDXW | Number of loads held |
| upd_valid | input | 1 | Record an executed load's address |
| upd_idx | input | IDXW | Slot being updated |
| upd_addr | input | AW | Effective address |
| chk_valid | input | 1 | Store ordering check request |
| chk_start | input | IDXW | Load tail captured at store allocation |
| chk_addr | input | AW | Store address |
| vio_pending | output | 1 | A violator is held |
| vio_idx | output | IDXW | Slot of the held violator |
| vio_take | input | 1 | Consume the held violator |
| commit_valid | input | 1 | Retire loads up to a boundary |
| commit_seq | input | SEQW | Commit boundary, inclusive |
| squash_valid | input | 1 | Flush loads younger than a boundary |
| squash_seq | input | SEQW | Squash boundary, exclusive |

## Verification
`alloc_sq_tag` is combinational, so the bench samples it one nanosecond after driving the inputs, before the clock edge. Every other result (occupancy, tail, `alloc_ready`, violator state) is registered once and is due on the edge that consumes the request. The bench therefore drives at the falling edge, advances its reference model at the rising edge, and compares all registered outputs at the next falling edge. The directed checks are sampled in that same slot, one edge after the stimulus.

// File: rtl/lq_pkg.sv
package lq_pkg;

  // index a advanced by n on a ring of the given size
  function automatic int unsigned ring_add(int unsigned a, int unsigned n, int unsigned ring);
    return (a + n) % ring;
  endfunction

  // index a moved back by n on a ring of the given size
  function automatic int unsigned ring_sub(int unsigned a, int unsigned n, int unsigned ring);
    return (a + ring - (n % ring)) % ring;
  endfunction

  // forward steps needed to go from index 'from' to index 'to'
  function automatic int unsigned ring_dist(int unsigned from, int unsigned to, int unsigned ring);
    return (to + ring - from) % ring;
  endfunction

endpackage

// File: rtl/lq_ring_ctrl.sv
module lq_ring_ctrl #(
  parameter int RING = 9,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IDXW-1:0] pop_n,
  input  logic [IDXW-1:0] cut_n,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] tail,
  output logic [IDXW-1:0] count,
  output logic            full
);
  import lq_pkg::*;

  logic [IDXW-1:0] head_q, tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= IDXW'(ring_add(32'(head_q), 32'(pop_n), RING));
      tail_q <= IDXW'(ring_sub(ring_add(32'(tail_q), 32'(push), RING), 32'(cut_n), RING));
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = IDXW'(ring_dist(32'(head_q), 32'(tail_q), RING));
  assign full  = (ring_add(32'(tail_q), 1, RING) == 32'(head_q));

endmodule

// File: rtl/lq_entry_store.sv
module lq_entry_store #(
  parameter int RING = 9,
  parameter int IDXW = 4,
  parameter int SEQW = 16,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [SEQW-1:0] wr_seq,
  input  logic            upd_en,
  input  logic [IDXW-1:0] upd_idx,
  input  logic [AW-1:0]   upd_addr,
  input  logic [RING-1:0] clr_mask,
  output logic [SEQW-1:0] seq_o  [RING],
  output logic [AW-1:0]   addr_o [RING],
  output logic [RING-1:0] av_o
);

  for (genvar i = 0; i < RING; i++) begin : g_slot
    logic [SEQW-1:0] seq_q;
    logic [AW-1:0]   addr_q;
    logic            av_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seq_q  <= '0;
        addr_q <= '0;
        av_q   <= 1'b0;
      end else begin
        if (wr_en && wr_idx == IDXW'(i)) begin
          seq_q <= wr_seq;
          av_q  <= 1'b0;
        end
        if (upd_en && upd_idx == IDXW'(i)) begin
          addr_q <= upd_addr;
          av_q   <= 1'b1;
        end
        if (clr_mask[i]) av_q <= 1'b0;
      end
    end

    assign seq_o[i]  = seq_q;
    assign addr_o[i] = addr_q;
    assign av_o[i]   = av_q;
  end

endmodule

// File: rtl/lq_order_scan.sv
module lq_order_scan #(
  parameter int RING = 9,
  parameter int IDXW = 4,
  parameter int AW   = 32,
  parameter int IGN  = 8
) (
  input  logic [IDXW-1:0] start,
  input  logic [IDXW-1:0] tail,
  input  logic [AW-1:0]   addr,
  input  logic [RING-1:0] av,
  input  logic [AW-1:0]   ent_addr [RING],
  output logic            hit,
  output logic [IDXW-1:0] hit_idx
);
  import lq_pkg::*;

  logic [RING-1:0] cand;
  int unsigned     best_d;

  for (genvar i = 0; i < RING; i++) begin : g_cmp
    assign cand[i] = av[i]
                   && (ent_addr[i][AW-1:IGN] == addr[AW-1:IGN])
                   && (ring_dist(32'(start), i, RING) < ring_dist(32'(start), 32'(tail), RING));
  end

  // nearest candidate in walk order from start
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    best_d  = RING;
    for (int i = 0; i < RING; i++) begin
      if (cand[i] && ring_dist(32'(start), i, RING) < best_d) begin
        best_d  = ring_dist(32'(start), i, RING);
        hit     = 1'b1;
        hit_idx = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/load_order_queue.sv
module load_order_queue #(
  parameter int DEPTH = 8,
  parameter int SEQW  = 16,
  parameter int AW    = 32,
  parameter int IGN   = 8,
  parameter int SQW   = 4,
  localparam int RING = DEPTH + 1,
  localparam int IDXW = $clog2(RING)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  input  logic [SEQW-1:0] alloc_seq,
  input  logic            alloc_sq_empty,
  input  logic [SQW-1:0]  alloc_sq_tail,
  output logic            alloc_ready,
  output logic [IDXW-1:0] alloc_idx,
  output logic [SQW:0]    alloc_sq_tag,
  output logic [IDXW-1:0] occupancy,
  input  logic            upd_valid,
  input  logic [IDXW-1:0] upd_idx,
  input  logic [AW-1:0]   upd_addr,
  input  logic            chk_valid,
  input  logic [IDXW-1:0] chk_start,
  input  logic [AW-1:0]   chk_addr,
  output logic            vio_pending,
  output logic [IDXW-1:0] vio_idx,
  input  logic            vio_take,
  input  logic            commit_valid,
  input  logic [SEQW-1:0] commit_seq,
  input  logic            squash_valid,
  input  logic [SEQW-1:0] squash_seq
);
  import lq_pkg::*;

  // named internal events
  logic            push;
  logic [IDXW-1:0] pop_n, cut_n;
  logic [IDXW-1:0] head_idx, tail_idx, count;
  logic            full;
  logic [RING-1:0] clr_mask, occ, av;
  logic [SEQW-1:0] seq_arr  [RING];
  logic [AW-1:0]   addr_arr [RING];
  logic            scan_hit;
  logic [IDXW-1:0] scan_idx;
  logic            scan_take;
  logic            vio_q;
  logic [IDXW-1:0] vio_idx_q;

  assign push = alloc_valid && !full && !squash_valid;

  lq_ring_ctrl #(.RING(RING), .IDXW(IDXW)) ring_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop_n(pop_n), .cut_n(cut_n),
    .head(head_idx), .tail(tail_idx), .count(count), .full(full)
  );

  for (genvar i = 0; i < RING; i++) begin : g_occ
    assign occ[i] = ring_dist(32'(head_idx), i, RING) < 32'(count);
  end

  // head-side retirement and tail-side flush counts
  always_comb begin
    logic [IDXW-1:0] p;
    logic            run;
    pop_n    = '0;
    cut_n    = '0;
    clr_mask = '0;
    run      = commit_valid;
    for (int k = 0; k < RING; k++) begin
      p = IDXW'(ring_add(32'(head_idx), k, RING));
      if (run && k < 32'(count) && seq_arr[p] <= commit_seq) begin
        pop_n       = IDXW'(32'(pop_n) + 1);
        clr_mask[p] = 1'b1;
      end else begin
        run = 1'b0;
      end
    end
    run = squash_valid;
    for (int k = 0; k < RING; k++) begin
      p = IDXW'(ring_sub(32'(tail_idx), k + 1, RING));
      if (run && k < 32'(count) && seq_arr[p] > squash_seq) begin
        cut_n       = IDXW'(32'(cut_n) + 1);
        clr_mask[p] = 1'b1;
      end else begin
        run = 1'b0;
      end
    end
  end

  lq_entry_store #(.RING(RING), .IDXW(IDXW), .SEQW(SEQW), .AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push), .wr_idx(tail_idx), .wr_seq(alloc_seq),
    .upd_en(upd_valid && occ[upd_idx]), .upd_idx(upd_idx), .upd_addr(upd_addr),
    .clr_mask(clr_mask),
    .seq_o(seq_arr), .addr_o(addr_arr), .av_o(av)
  );

  lq_order_scan #(.RING(RING), .IDXW(IDXW), .AW(AW), .IGN(IGN)) scan_i (
    .start(chk_start), .tail(tail_idx), .addr(chk_addr),
    .av(av), .ent_addr(addr_arr),
    .hit(scan_hit), .hit_idx(scan_idx)
  );

  assign scan_take = chk_valid && !vio_q && scan_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vio_q     <= 1'b0;
      vio_idx_q <= '0;
    end else begin
      if (vio_take) vio_q <= 1'b0;
      if (scan_take) begin
        vio_q     <= 1'b1;
        vio_idx_q <= scan_idx;
      end
    end
  end

  assign alloc_ready  = !full;
  assign alloc_idx    = tail_idx;
  assign alloc_sq_tag = alloc_sq_empty ? '1 : {1'b0, alloc_sq_tail};
  assign occupancy    = count;
  assign vio_pending  = vio_q;
  assign vio_idx      = vio_idx_q;

endmodule

// File: rtl/lq_checker.sv
module lq_checker #(
  parameter int DEPTH = 8,
  localparam int RING = DEPTH + 1,
  localparam int IDXW = $clog2(RING)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alloc_valid,
  input logic            alloc_ready,
  input logic [IDXW-1:0] alloc_idx,
  input logic [IDXW-1:0] occupancy,
  input logic            chk_valid,
  input logic            vio_pending,
  input logic [IDXW-1:0] vio_idx,
  input logic            vio_take,
  input logic            commit_valid,
  input logic            squash_valid
);

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= IDXW'(DEPTH)); // R1

  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ready |=> occupancy <= $past(occupancy)); // R1

  AST_ALLOC_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready && !commit_valid && !squash_valid
    |=> occupancy == $past(occupancy) + 1'b1); // R2

  AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready && !commit_valid && !squash_valid
    |=> alloc_idx == (($past(alloc_idx) == IDXW'(RING - 1)) ? '0 : $past(alloc_idx) + 1'b1)); // R2

  AST_COMMIT_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && !alloc_valid |=> occupancy <= $past(occupancy)); // R4

  AST_SQUASH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> occupancy <= $past(occupancy)); // R9

  AST_RETIRE_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_valid && squash_valid)); // R9

  AST_NO_CHECK_NO_VIO: assert property (@(posedge clk) disable iff (!rst_n)
    !vio_pending && !chk_valid |=> !vio_pending); // R7

  AST_VIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vio_pending && !vio_take |=> vio_pending && vio_idx == $past(vio_idx)); // R8

  AST_VIO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    vio_pending && vio_take |=> !vio_pending); // R8

endmodule

bind load_order_queue lq_checker #(.DEPTH(DEPTH)) lq_checker_i (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_idx(alloc_idx), .occupancy(occupancy), .chk_valid(chk_valid),
  .vio_pending(vio_pending), .vio_idx(vio_idx), .vio_take(vio_take),
  .commit_valid(commit_valid), .squash_valid(squash_valid)
);

// File: tb/load_order_queue_tb_top.sv
`timescale 1ns/100ps
module load_order_queue_tb_top;
  localparam int DEPTH = 8;
  localparam int SEQW  = 16;
  localparam int AW    = 32;
  localparam int IGN   = 8;
  localparam int SQW   = 4;
  localparam int RING  = DEPTH + 1;
  localparam int IDXW  = $clog2(RING);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            alloc_valid = 1'b0;
  logic [SEQW-1:0] alloc_seq = '0;
  logic            alloc_sq_empty = 1'b0;
  logic [SQW-1:0]  alloc_sq_tail = '0;
  logic            alloc_ready;
  logic [IDXW-1:0] alloc_idx;
  logic [SQW:0]    alloc_sq_tag;
  logic [IDXW-1:0] occupancy;
  logic            upd_valid = 1'b0;
  logic [IDXW-1:0] upd_idx = '0;
  logic [AW-1:0]   upd_addr = '0;
  logic            chk_valid = 1'b0;
  logic [IDXW-1:0] chk_start = '0;
  logic [AW-1:0]   chk_addr = '0;
  logic            vio_pending;
  logic [IDXW-1:0] vio_idx;
  logic            vio_take = 1'b0;
  logic            commit_valid = 1'b0;
  logic [SEQW-1:0] commit_seq = '0;
  logic            squash_valid = 1'b0;
  logic [SEQW-1:0] squash_seq = '0;

  load_order_queue #(.DEPTH(DEPTH), .SEQW(SEQW), .AW(AW), .IGN(IGN), .SQW(SQW)) dut_i (.*);

  always #2.5 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R10";
  bit    done    = 1'b0;

  // behavioural reference
  int       q_idx[$];
  int       m_seq  [RING];
  bit [31:0] m_addr [RING];
  bit       m_av   [RING];
  bit       m_occ  [RING];
  int       m_head = 0, m_tail = 0;
  bit       m_vp = 0;
  int       m_vi = 0;
  int       next_seq = 1;

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; upd_valid = 0; chk_valid = 0; vio_take = 0;
    commit_valid = 0; squash_valid = 0;
  endtask

  task automatic model_step();
    bit full, found;
    int p;
    full  = (q_idx.size() == DEPTH);
    found = 0;
    p     = 0;
    if (chk_valid && !m_vp) begin
      p = int'(chk_start);
      while (p != m_tail) begin
        if (m_occ[p] && m_av[p] && ((m_addr[p] >> IGN) == (chk_addr >> IGN))) begin
          found = 1;
          break;
        end
        p = (p + 1) % RING;
      end
    end
    if (vio_take) m_vp = 0;
    if (found) begin m_vp = 1; m_vi = p; end
    if (upd_valid && m_occ[upd_idx]) begin
      m_addr[upd_idx] = upd_addr;
      m_av[upd_idx]   = 1;
    end
    if (commit_valid)
      while (q_idx.size() > 0 && m_seq[q_idx[0]] <= int'(commit_seq)) begin
        p = q_idx.pop_front();
        m_occ[p] = 0; m_av[p] = 0;
        m_head = (m_head + 1) % RING;
      end
    if (squash_valid)
      while (q_idx.size() > 0 && m_seq[q_idx[$]] > int'(squash_seq)) begin
        p = q_idx.pop_back();
        m_occ[p] = 0; m_av[p] = 0;
        m_tail = (m_tail + RING - 1) % RING;
      end
    if (alloc_valid && !full && !squash_valid) begin
      m_seq[m_tail] = int'(alloc_seq);
      m_av[m_tail]  = 0;
      m_occ[m_tail] = 1;
      q_idx.push_back(m_tail);
      m_tail = (m_tail + 1) % RING;
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "occupancy", occupancy, q_idx.size());
    chk(cur_req, "alloc_ready", alloc_ready, q_idx.size() != DEPTH);
    chk(cur_req, "alloc_idx", alloc_idx, m_tail);
    chk(cur_req, "vio_pending", vio_pending, m_vp);
    if (m_vp) chk(cur_req, "vio_idx", vio_idx, m_vi);
  endtask

  // inputs set at a falling edge; one clock is applied
  task automatic tick();
    #1;
    chk("R3", "alloc_sq_tag", alloc_sq_tag,
        alloc_sq_empty ? (1 << (SQW + 1)) - 1 : int'(alloc_sq_tail));
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic do_alloc(int n);
    for (int i = 0; i < n; i++) begin
      alloc_valid = 1; alloc_seq = SEQW'(next_seq); next_seq++;
      tick();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < RING; i++) begin
      m_seq[i] = 0; m_addr[i] = 0; m_av[i] = 0; m_occ[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "occupancy", occupancy, 0);
    chk("R10", "alloc_ready", alloc_ready, 1);
    chk("R10", "vio_pending", vio_pending, 0);
    chk("R10", "alloc_idx", alloc_idx, 0);

    // R3 store-queue tag
    cur_req = "R3";
    alloc_sq_empty = 1; #1;
    chk("R3", "tag empty", alloc_sq_tag, 31);
    alloc_sq_empty = 0; alloc_sq_tail = 4'd5; #1;
    chk("R3", "tag tail", alloc_sq_tag, 5);
    @(negedge clk);

    // R1 / R2 fill to depth
    cur_req = "R2";
    do_alloc(DEPTH);
    chk("R1", "occupancy full", occupancy, DEPTH);
    chk("R1", "alloc_ready full", alloc_ready, 0);
    chk("R2", "tail after fill", alloc_idx, DEPTH);
    cur_req = "R1";
    do_alloc(1);
    chk("R1", "refused alloc", occupancy, DEPTH);

    // R4 partial commit: seqs 1..8 held, boundary 3
    cur_req = "R4";
    commit_valid = 1; commit_seq = 16'd3; tick();
    chk("R4", "after commit", occupancy, 5);
    commit_valid = 1; commit_seq = 16'd2; tick();
    chk("R4", "stale boundary", occupancy, 5);

    // R2 tail wrap
    cur_req = "R2";
    do_alloc(1);
    chk("R2", "tail wrapped", alloc_idx, 0);
    do_alloc(1);
    chk("R2", "tail after wrap", alloc_idx, 1);

    // R5 squash, including tail wrap backwards
    cur_req = "R5";
    squash_valid = 1; squash_seq = SEQW'(m_seq[8]); tick();
    chk("R5", "tail back", alloc_idx, 0);
    squash_valid = 1; squash_seq = SEQW'(m_seq[7]); tick();
    chk("R5", "tail back wrap", alloc_idx, 8);
    chk("R5", "occupancy", occupancy, 5);

    // R9 alloc during squash refused
    cur_req = "R9";
    alloc_valid = 1; alloc_seq = SEQW'(next_seq); next_seq++;
    squash_valid = 1; squash_seq = 16'hFFFF; tick();
    chk("R9", "alloc with squash", occupancy, 5);

    // R6 / R7 ordering checks; slots 3..7 held
    cur_req = "R6";
    upd_valid = 1; upd_idx = 4'd4; upd_addr = 32'h1234_56AB; tick();
    upd_valid = 1; upd_idx = 4'd6; upd_addr = 32'h1234_5600; tick();
    upd_valid = 1; upd_idx = 4'd0; upd_addr = 32'h0000_0000; tick();
    chk_valid = 1; chk_start = 4'd5; chk_addr = 32'h0000_0010; tick();
    chk("R6", "invalid address no match", vio_pending, 0);
    cur_req = "R7";
    chk_valid = 1; chk_start = 4'd3; chk_addr = 32'h1234_56FF; tick();
    chk("R7", "first match", vio_idx, 4);
    chk("R7", "pending", vio_pending, 1);
    vio_take = 1; tick();
    chk("R8", "take clears", vio_pending, 0);
    chk_valid = 1; chk_start = 4'd5; chk_addr = 32'h1234_5777; tick();
    chk("R7", "bit 8 differs", vio_pending, 0);
    chk_valid = 1; chk_start = 4'd7; chk_addr = 32'h1234_5600; tick();
    chk("R7", "window excludes older", vio_pending, 0);
    chk_valid = 1; chk_start = 4'd5; chk_addr = 32'h1234_5677; tick();
    chk("R7", "skips to later slot", vio_idx, 6);

    // R8 pending blocks later checks
    cur_req = "R8";
    chk_valid = 1; chk_start = 4'd3; chk_addr = 32'h1234_5601; tick();
    chk("R8", "held violator", vio_idx, 6);
    vio_take = 1; chk_valid = 1; chk_start = 4'd3; chk_addr = 32'h1234_5601; tick();
    chk("R8", "cleared by take", vio_pending, 0);

    // mixed traffic against the reference
    cur_req = "random";
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = $urandom % 100;
      alloc_valid = (r < 45);
      alloc_seq = SEQW'(next_seq);
      if (alloc_valid) next_seq++;
      alloc_sq_empty = ($urandom % 4) == 0;
      alloc_sq_tail = SQW'($urandom);
      upd_valid = ($urandom % 3) == 0;
      upd_idx = IDXW'($urandom % RING);
      upd_addr = {22'd0, 2'($urandom), 8'($urandom)};
      chk_valid = ($urandom % 4) == 0;
      chk_start = IDXW'((m_head + ($urandom % (q_idx.size() + 1))) % RING);
      chk_addr = {22'd0, 2'($urandom), 8'($urandom)};
      vio_take = ($urandom % 3) == 0;
      r = $urandom % 100;
      if (r < 15 && q_idx.size() > 0) begin
        commit_valid = 1;
        commit_seq = SEQW'(m_seq[q_idx[0]] + int'($urandom % 3) - 1);
      end else if (r < 20 && q_idx.size() > 0) begin
        squash_valid = 1;
        squash_seq = SEQW'(m_seq[q_idx[$]] - int'($urandom % 3));
      end
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule